// File: doc/BRIEF.md
# One-Wire Bus Master Controller

This block is the master side of a single-wire, open-drain serial bus. Software starts each bus operation by writing a request bit into a small command register. The hardware then runs the operation and clears that bit on its own when the operation is over. Three operations are available:

- a bus reset followed by a listening window for a device's presence answer;
- a "write 0" time slot;
- a combined "write 1 / read" time slot, which samples the line early in the slot.

Two status bits keep the results. One records whether a device answered the last reset. The other holds the line value captured by the last write-1/read slot.

All slot timing is counted in microseconds from a one-cycle enable pulse, `usTick`, which the surrounding logic derives from the system clock. The block's only bus output is `pullLow`, the enable of the open-drain pull-down. `lineIn` is the already-synchronised level of the wire. Only one operation runs at a time, and the busy bit lets software poll for completion. Byte sequencing, device addressing and CRC are left to the layers above.

Top module: `swire_host`

## Requirements
- R1: While `rstN` is low, and right after it, `rdData` reads all zeros and `pullLow` is 0. This also holds when reset arrives in the middle of an operation.
- R2: The register fields are as follows.
  - `wrCmd` bit 0 requests a bus reset, bit 1 a write-0 slot, and bit 2 a write-1/read slot.
  - `rdData` bits 2..0 read back those request bits, bit 3 is presence, bit 4 is the read bit and bit 5 is busy.
  - A write with any request bit set, made while idle, starts the operation on that clock edge. Busy and the written request bits read 1 from the next cycle.
- R3: A bus reset holds `pullLow` for 512 µs ticks, then releases the line for 512 more, so busy lasts 1024 ticks.
- R4: The presence bit is cleared when a bus reset starts. It is set if `lineIn` is low on any tick from 15 ticks after release until the end of the reset. It then keeps its value until the next bus reset.
- R5: A write-0 slot holds `pullLow` for 100 ticks within a slot of 117 ticks.
- R6: A write-1/read slot holds `pullLow` for 6 ticks within a slot of 117 ticks. It stores `lineIn` into the read bit on the 14th tick of the slot (slot counter at 13).
- R7: When an operation ends, all request bits and busy return to 0 on the same edge.
- R8: A write made while busy changes neither the request bits nor the running operation, and starts nothing after it.
- R9: When several request bits are written at once, only one operation runs: reset first, then write-0, then write-1/read. All of the written bits clear when it ends.
- R10: Only a write-1/read slot changes the read bit, and only a bus reset changes the presence bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| usTick | input | 1 | One-cycle pulse per microsecond |
| wrEn | input | 1 | Command register write strobe |
| wrCmd | input | 3 | Request bits: reset, write-0, write-1/read |
| rdData | output | 6 | Request bits, presence, read bit, busy |
| lineIn | input | 1 | Synchronised bus level |
| pullLow | output | 1 | Open-drain pull-down enable |

## Verification
Operations are issued in random order and with random request combinations. The microsecond tick arrives at an irregular cadence, so durations that are counted in clock cycles instead of ticks would show up as wrong tick counts. A bench responder can be present or absent, and can answer with a presence pulse after a random delay and length. Splitting the cases this way separates a missed presence window from a false detection, and a captured 0 from a captured 1. Directed cases cover the following:
- several request bits written together, which must pick the right winner;
- writes landing in the middle of a slot, which must be ignored;
- a reset arriving mid-operation;
- status bits that the other operations must leave alone.

// File: rtl/swire_pkg.sv
package swire_pkg;

  // Command / status register layout
  localparam int CMD_W    = 3;
  localparam int RD_W     = 6;
  localparam int BIT_RST  = 0;
  localparam int BIT_WR0  = 1;
  localparam int BIT_WR1  = 2;
  localparam int BIT_PRES = 3;
  localparam int BIT_RDV  = 4;
  localparam int BIT_BUSY = 5;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_RESET = 2'd1,
    OP_WR0   = 2'd2,
    OP_WR1RD = 2'd3
  } op_e;

  // Strobes from the sequencer to the register datapath
  typedef struct packed {
    logic startReset;
    logic clrReq;
    logic setPres;
    logic capRead;
  } strobe_t;

endpackage

// File: rtl/swire_ctrl.sv
module swire_ctrl
  import swire_pkg::*;
#(
  parameter int RST_LOW_US    = 512,
  parameter int RST_LISTEN_US = 512,
  parameter int PRES_GUARD_US = 15,
  parameter int SLOT_US       = 117,
  parameter int WR0_LOW_US    = 100,
  parameter int WR1_LOW_US    = 6,
  parameter int SAMPLE_US     = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usTick,
  input  logic             wrEn,
  input  logic [CMD_W-1:0] wrCmd,
  input  logic             lineIn,
  output logic             opActive,
  output logic             pullLow,
  output strobe_t          strb
);

  localparam int RST_TOTAL   = RST_LOW_US + RST_LISTEN_US;
  localparam int MAX_TOTAL   = (RST_TOTAL > SLOT_US) ? RST_TOTAL : SLOT_US;
  localparam int CNT_W       = $clog2(MAX_TOTAL + 1);
  localparam int LISTEN_FROM = RST_LOW_US + PRES_GUARD_US;

  op_e              curOp;
  op_e              newOp;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lowLen;
  logic [CNT_W-1:0] totLen;
  logic             lastTick;

  // Request decode with fixed priority: reset, write-0, write-1/read
  always_comb begin
    newOp = OP_NONE;
    if (wrEn) begin
      if (wrCmd[BIT_RST])      newOp = OP_RESET;
      else if (wrCmd[BIT_WR0]) newOp = OP_WR0;
      else if (wrCmd[BIT_WR1]) newOp = OP_WR1RD;
    end
  end

  // Per-operation timing
  always_comb begin
    case (curOp)
      OP_RESET: begin lowLen = CNT_W'(RST_LOW_US); totLen = CNT_W'(RST_TOTAL); end
      OP_WR0:   begin lowLen = CNT_W'(WR0_LOW_US); totLen = CNT_W'(SLOT_US);   end
      OP_WR1RD: begin lowLen = CNT_W'(WR1_LOW_US); totLen = CNT_W'(SLOT_US);   end
      default:  begin lowLen = '0;                 totLen = CNT_W'(SLOT_US);   end
    endcase
  end

  assign opActive = (curOp != OP_NONE);
  assign lastTick = opActive && usTick && (cnt == totLen - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOp <= OP_NONE;
      cnt   <= '0;
    end else if (!opActive) begin
      curOp <= newOp;
      cnt   <= '0;
    end else if (usTick) begin
      if (lastTick) begin
        curOp <= OP_NONE;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign pullLow = opActive && (cnt < lowLen);

  always_comb begin
    strb.startReset = !opActive && (newOp == OP_RESET);
    strb.clrReq     = lastTick;
    strb.setPres    = (curOp == OP_RESET) && usTick && !lineIn &&
                      (cnt >= CNT_W'(LISTEN_FROM));
    strb.capRead    = (curOp == OP_WR1RD) && usTick &&
                      (cnt == CNT_W'(SAMPLE_US));
  end

endmodule

// File: rtl/swire_datapath.sv
module swire_datapath
  import swire_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CMD_W-1:0] wrCmd,
  input  logic             lineIn,
  input  logic             opActive,
  input  strobe_t          strb,
  output logic [RD_W-1:0]  rdData
);

  logic [CMD_W-1:0] reqBits;
  logic             presence;
  logic             readBit;

  // Request bits: accepted only while idle, cleared when the operation ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqBits <= '0;
    end else if (strb.clrReq) begin
      reqBits <= '0;
    end else if (wrEn && !opActive) begin
      reqBits <= wrCmd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presence <= 1'b0;
    end else if (strb.startReset) begin
      presence <= 1'b0;
    end else if (strb.setPres) begin
      presence <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readBit <= 1'b0;
    end else if (strb.capRead) begin
      readBit <= lineIn;
    end
  end

  always_comb begin
    rdData                   = '0;
    rdData[CMD_W-1:0]        = reqBits;
    rdData[BIT_PRES]         = presence;
    rdData[BIT_RDV]          = readBit;
    rdData[BIT_BUSY]         = opActive;
  end

endmodule

// File: rtl/swire_host.sv
module swire_host
  import swire_pkg::*;
#(
  parameter int RST_LOW_US    = 512,
  parameter int RST_LISTEN_US = 512,
  parameter int PRES_GUARD_US = 15,
  parameter int SLOT_US       = 117,
  parameter int WR0_LOW_US    = 100,
  parameter int WR1_LOW_US    = 6,
  parameter int SAMPLE_US     = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        usTick,
  input  logic        wrEn,
  input  logic [2:0]  wrCmd,
  output logic [5:0]  rdData,
  input  logic        lineIn,
  output logic        pullLow
);

  logic    opActive;
  strobe_t strb;

  swire_ctrl #(
    .RST_LOW_US   (RST_LOW_US),
    .RST_LISTEN_US(RST_LISTEN_US),
    .PRES_GUARD_US(PRES_GUARD_US),
    .SLOT_US      (SLOT_US),
    .WR0_LOW_US   (WR0_LOW_US),
    .WR1_LOW_US   (WR1_LOW_US),
    .SAMPLE_US    (SAMPLE_US)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .usTick  (usTick),
    .wrEn    (wrEn),
    .wrCmd   (wrCmd),
    .lineIn  (lineIn),
    .opActive(opActive),
    .pullLow (pullLow),
    .strb    (strb)
  );

  swire_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrCmd   (wrCmd),
    .lineIn  (lineIn),
    .opActive(opActive),
    .strb    (strb),
    .rdData  (rdData)
  );

endmodule

// File: rtl/swire_host_chk.sv
module swire_host_chk (
  input logic       clk,
  input logic       rstN,
  input logic       opActive,
  input logic       clrReq,
  input logic       pullLow,
  input logic [5:0] rdData
);

  // R1: no pull-down while the block is idle
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[5] |-> !pullLow);

  // R2: an operation begins by pulling the line low
  a_r2_start_pulls: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opActive) |-> pullLow);

  // R4: presence can only rise as a result of a running operation
  a_r4_pres_in_op: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[3]) |-> $past(opActive));

  // R7: request bits are clear once the operation drops
  a_r7_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(opActive) |-> (rdData[2:0] == 3'b000));

  // R8: request bits hold while busy until the closing tick
  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (opActive && !clrReq) |=> (rdData[2:0] == $past(rdData[2:0])));

  // R9: some request bit stays visible for the whole operation
  a_r9_req_visible: assert property (@(posedge clk) disable iff (!rstN)
    opActive |-> (rdData[2:0] != 3'b000));

  // R10: read bit changes only as a result of a running operation
  a_r10_rdbit_in_op: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData[4]) |-> $past(opActive));

endmodule

bind swire_host swire_host_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opActive(opActive),
  .clrReq  (strb.clrReq),
  .pullLow (pullLow),
  .rdData  (rdData)
);

// File: tb/swire_host_bench.sv
module swire_host_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       usTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrCmd = 3'b000;
  logic [5:0] rdData;
  logic       lineIn;
  logic       pullLow;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // responder state
  bit devPresent = 1;
  bit devBit = 1;
  int presDelay = 100;
  int presLen = 120;
  int lowRun = 0, bitHold = 0, presWait = 0, presHold = 0;
  bit prevPull = 0;
  bit devLow = 0;

  // monitor counters
  int lowTicks = 0, busyTicks = 0;

  // expected status
  bit expPres = 0, expRd = 0;

  always #2 clk = ~clk;

  assign lineIn = !(pullLow || devLow);

  swire_host u_swire_host (
    .clk(clk), .rstN(rstN), .usTick(usTick), .wrEn(wrEn), .wrCmd(wrCmd),
    .rdData(rdData), .lineIn(lineIn), .pullLow(pullLow)
  );

  // irregular microsecond tick
  initial begin
    void'($urandom(11));
    forever begin
      @(posedge clk);
      #1 usTick = ($urandom_range(0, 2) == 0);
    end
  end

  // tick counting and responder, both away from the active edge
  always @(negedge clk) begin
    if (usTick && rdData[5]) busyTicks++;
    if (usTick && pullLow)   lowTicks++;
    if (pullLow && !prevPull) bitHold = devBit ? 0 : 45;
    if (!pullLow && prevPull) begin
      if (lowRun >= 400 && devPresent) presWait = presDelay;
      lowRun = 0;
    end
    if (usTick) begin
      if (pullLow) lowRun++;
      if (bitHold > 0) bitHold--;
      if (presWait > 0) begin
        presWait--;
        if (presWait == 0) presHold = presLen;
      end else if (presHold > 0) presHold--;
    end
    prevPull = pullLow;
    devLow = (bitHold > 0) || (presHold > 0);
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int winOp(logic [2:0] b);
    if (b[0]) return 0;
    if (b[1]) return 1;
    return 2;
  endfunction

  function automatic int expLow(logic [2:0] b);
    case (winOp(b))
      0: return 512;
      1: return 100;
      default: return 6;
    endcase
  endfunction

  function automatic int expTot(logic [2:0] b);
    return (winOp(b) == 0) ? 1024 : 117;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // one operation, optionally with a write landing mid-operation
  task automatic doOp(logic [2:0] bits, logic [2:0] midBits, bit useMid);
    int guard = 0;
    string rq;
    rq = (winOp(bits) == 0) ? "R3" : (winOp(bits) == 1) ? "R5" : "R6";
    lowTicks = 0;
    busyTicks = 0;
    @(posedge clk); #1 wrEn = 1; wrCmd = bits;
    @(posedge clk); #1 wrEn = 0; wrCmd = 3'b000;
    chk("R2", "busy after request", rdData[5], 1);
    chk("R2", "request readback", rdData[2:0], bits);
    if (useMid) begin
      repeat (20) @(negedge clk);
      @(posedge clk); #1 wrEn = 1; wrCmd = midBits;
      @(posedge clk); #1 wrEn = 0; wrCmd = 3'b000;
      chk("R8", "request bits after busy write", rdData[2:0], bits);
    end
    while (rdData[5] && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk("R7", "busy cleared", rdData[5], 0);
    chk("R7", "requests self-cleared", rdData[2:0], 0);
    chk(rq, "low ticks", lowTicks, expLow(bits));
    chk(rq, "busy ticks", busyTicks, expTot(bits));
    if (winOp(bits) == 0) expPres = devPresent;
    if (winOp(bits) == 2) expRd = devBit;
    chk("R4", "presence", rdData[3], expPres);
    chk("R10", "read bit", rdData[4], expRd);
    if (useMid) begin
      repeat (30) @(negedge clk);
      chk("R8", "no late start busy", rdData[5], 0);
      chk("R8", "no late start line", pullLow, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(5));
    repeat (4) @(negedge clk);
    chk("R1", "rdData in reset", rdData, 0);
    chk("R1", "pullLow in reset", pullLow, 0);
    @(posedge clk); #1 rstN = 1;
    @(negedge clk);
    chk("R1", "rdData after reset", rdData, 0);

    // directed: presence seen, absent, and late pulse
    devPresent = 1; presDelay = 60; presLen = 100;
    doOp(3'b001, 3'b000, 0);
    devPresent = 0;
    doOp(3'b001, 3'b000, 0);
    devPresent = 1; presDelay = 240; presLen = 30;
    doOp(3'b001, 3'b000, 0);

    // directed: read 0, read 1, write0 leaves read bit alone (R10)
    devBit = 0; doOp(3'b100, 3'b000, 0);
    devBit = 1; doOp(3'b010, 3'b000, 0);
    doOp(3'b100, 3'b000, 0);
    devBit = 0; doOp(3'b010, 3'b000, 0);

    // R9: priority among combined requests
    doOp(3'b110, 3'b000, 0);
    devPresent = 0; doOp(3'b111, 3'b000, 0);

    // R8: writes while busy are ignored
    devBit = 1; doOp(3'b100, 3'b001, 1);
    doOp(3'b010, 3'b101, 1);

    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [2:0] b;
      b = 3'($urandom_range(1, 7));
      if (b[0] && ($urandom_range(0, 2) != 0)) b[0] = 1'b0;
      if (b == 3'b000) b = 3'b100;
      devPresent = $urandom_range(0, 1);
      devBit = $urandom_range(0, 1);
      presDelay = $urandom_range(60, 240);
      presLen = $urandom_range(20, 200);
      doOp(b, 3'($urandom_range(1, 7)), $urandom_range(0, 3) == 0);
    end

    // R1: reset in the middle of a bus reset
    @(posedge clk); #1 wrEn = 1; wrCmd = 3'b001;
    @(posedge clk); #1 wrEn = 0; wrCmd = 3'b000;
    repeat (100) @(negedge clk);
    @(posedge clk); #1 rstN = 0;
    @(negedge clk);
    chk("R1", "rdData after mid-op reset", rdData, 0);
    chk("R1", "pullLow after mid-op reset", pullLow, 0);
    @(posedge clk); #1 rstN = 1;
    expPres = 0; expRd = 0;
    repeat (400) @(negedge clk);
    chk("R1", "still idle after reset", rdData, 0);

    finishRun();
  end

endmodule